// File: doc/BRIEF.md
# SMI Wake and Temporary-On Controller

This block gathers system-management interrupt requests from a set of power-management event sources and drives a single interrupt line to the processor. Each source has its own enable bit. An enabled event latches a sticky status bit, and the interrupt line stays high while any enabled status bit is set. Software reads the status register to find the cause and clears bits by writing ones to them.

Three of the sources can wake the machine: a mode-change request, a wake-level battery-low warning and a resume keystroke. If one of these arrives while the clocks are stopped, the block forces the CPU, DMA and internal clock-run enables on. This is the temporary-on state. In this state the frequency select points at the fixed low-frequency reference, unless the PMU is in one of its PLL modes. Temporary-on does not end when software writes the control register. It ends at the first refresh tick after that write.

A resume keystroke also asks the mode logic to move to high-speed PLL mode. Its interrupt is held back until the reported mode is high-speed PLL.

Top module: `smi_wake_ctrl`

## Requirements
- R1: A one-cycle event on source i sets status bit i at the next clock edge only if enable bit i is set. A disabled event leaves the status register unchanged. Source order is: bit 0 mode-change (wake), bit 1 battery-low wake level, bit 2 resume key (wake), bit 3 battery-low warning level, bit 4 access to powered-off peripheral, bit 5 timer tick.
- R2: `smi_o` is high whenever a status bit other than resume is set together with its enable bit. It rises in the cycle after the latching edge.
- R3: A register write to address 1 clears exactly the status bits written as 1. If an event on a bit arrives in the same cycle as its clear, the set takes priority and the bit stays 1.
- R4: An enabled wake-source event (bits 0 to 2) while `clk_stopped_i` is high makes every bit of `run_en_o` 1 after the next edge. An enabled non-wake event leaves `run_en_o` at 0.
- R5: `freq_sel_o` encodes 0 = high-speed PLL, 1 = low-speed PLL, 2 = fixed reference, 3 = off. During temporary-on it is 2 unless the mode is a PLL mode, in which case it follows the mode. Outside temporary-on it maps mode 0 to 0, mode 1 to 1, mode 2 (doze) to 2 and mode 3 (stop) to 3.
- R6: Temporary-on ends at the first `refresh_i` pulse sampled at a clock edge after the edge that took a write to the control register (address 2). A refresh in the same cycle as that write, or a refresh with no write, leaves it on.
- R7: While the resume status bit is set and enabled and `mode_i` is not 0 (high-speed PLL), `hs_req_o` is high and the resume bit does not raise `smi_o`. Once `mode_i` is 0, `hs_req_o` falls and `smi_o` rises in that same cycle.
- R8: Mode-change and battery-low wake events never raise `hs_req_o`.
- R9: Reads return enable bits at address 0 and status bits at address 1. At address 2 they return bit 0 = temporary-on and bit 1 = release pending. All other bits read 0.
- R10: After reset the enables, status, temporary-on and release-pending are 0, and `smi_o`, `hs_req_o` and `run_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NSRC | One-cycle event pulses, one per source |
| clk_stopped_i | input | 1 | High when the mode logic has stopped the clocks |
| mode_i | input | 2 | Current PMU mode: 0 high PLL, 1 low PLL, 2 doze, 3 stop |
| refresh_i | input | 1 | Refresh tick pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data (combinational on address) |
| smi_o | output | 1 | Interrupt request to the processor |
| hs_req_o | output | 1 | Request to switch to high-speed PLL mode |
| run_en_o | output | NCLK | Forced clock-run enables (CPU, DMA, internal) |
| freq_sel_o | output | 2 | Frequency select |

## Verification
Status bits, temporary-on and release-pending are registered, so their effects on `reg_rdata_o`, `smi_o` and `run_en_o` show one edge after the event or write. `hs_req_o`, `freq_sel_o` and the resume gating of `smi_o` are combinational on `mode_i`. The bench therefore drives all inputs on the falling edge and checks registered results at the next falling edge. It checks combinational results one time step after changing `mode_i`. Each refresh and write is lined up edge by edge to show that only a tick after the write-capturing edge ends temporary-on.

// File: rtl/smi_wake_pkg.sv
package smi_wake_pkg;

    typedef enum logic [1:0] {
        MODE_HI_PLL = 2'd0,
        MODE_LO_PLL = 2'd1,
        MODE_DOZE   = 2'd2,
        MODE_STOP   = 2'd3
    } pmu_mode_e;

    typedef enum logic [1:0] {
        FSEL_HI  = 2'd0,
        FSEL_LO  = 2'd1,
        FSEL_REF = 2'd2,
        FSEL_OFF = 2'd3
    } fsel_e;

    localparam logic [1:0] ADDR_ENABLE = 2'd0;
    localparam logic [1:0] ADDR_STATUS = 2'd1;
    localparam logic [1:0] ADDR_CTRL   = 2'd2;

endpackage

// File: rtl/smi_src_bank.sv
module smi_src_bank #(
    parameter int NSRC = 6,
    parameter logic [NSRC-1:0] WAKE_MASK = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic            en_wr_i,
    input  logic            clr_wr_i,
    input  logic [NSRC-1:0] wdata_i,
    output logic [NSRC-1:0] en_o,
    output logic [NSRC-1:0] stat_o,
    output logic            wake_o
);

    typedef struct packed {
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] stat;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [NSRC-1:0] hits;

    always_comb begin
        bank_d = bank_q;
        hits   = evt_i & bank_q.en;
        if (en_wr_i) begin
            bank_d.en = wdata_i;
        end
        if (clr_wr_i) begin
            bank_d.stat = bank_q.stat & ~wdata_i;
        end
        // a fresh event wins over a clear of the same bit
        bank_d.stat = bank_d.stat | hits;
        wake_o      = |(hits & WAKE_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign en_o   = bank_q.en;
    assign stat_o = bank_q.stat;

endmodule

// File: rtl/smi_tempon_seq.sv
module smi_tempon_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_i,
    input  logic clk_stopped_i,
    input  logic ctl_wr_i,
    input  logic refresh_i,
    output logic temp_on_o,
    output logic rel_pend_o
);

    typedef struct packed {
        logic temp_on;
        logic rel_pend;
    } seq_t;

    seq_t seq_d, seq_q;
    logic ending;

    always_comb begin
        seq_d  = seq_q;
        ending = seq_q.temp_on & seq_q.rel_pend & refresh_i;
        if (ctl_wr_i && seq_q.temp_on) begin
            seq_d.rel_pend = 1'b1;
        end
        if (ending) begin
            seq_d.temp_on  = 1'b0;
            seq_d.rel_pend = 1'b0;
        end
        // a wake while stopped (re)opens the window with no release armed
        if (wake_i && clk_stopped_i && !seq_d.temp_on) begin
            seq_d.temp_on  = 1'b1;
            seq_d.rel_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign temp_on_o  = seq_q.temp_on;
    assign rel_pend_o = seq_q.rel_pend;

endmodule

// File: rtl/smi_reg_port.sv
module smi_reg_port
    import smi_wake_pkg::*;
#(
    parameter int NSRC = 6,
    parameter int AW   = 2,
    parameter int DW   = 8
) (
    input  logic            we_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [NSRC-1:0] en_i,
    input  logic [NSRC-1:0] stat_i,
    input  logic            temp_on_i,
    input  logic            rel_pend_i,
    output logic            en_wr_o,
    output logic            clr_wr_o,
    output logic            ctl_wr_o,
    output logic [DW-1:0]   rdata_o
);

    localparam int PAD = DW - NSRC;

    always_comb begin
        en_wr_o  = we_i && (addr_i == AW'(ADDR_ENABLE));
        clr_wr_o = we_i && (addr_i == AW'(ADDR_STATUS));
        ctl_wr_o = we_i && (addr_i == AW'(ADDR_CTRL));
        rdata_o  = '0;
        unique case (addr_i)
            AW'(ADDR_ENABLE): rdata_o = {{PAD{1'b0}}, en_i};
            AW'(ADDR_STATUS): rdata_o = {{PAD{1'b0}}, stat_i};
            AW'(ADDR_CTRL):   rdata_o = {{(DW-2){1'b0}}, rel_pend_i, temp_on_i};
            default:          rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/smi_wake_ctrl.sv
module smi_wake_ctrl
    import smi_wake_pkg::*;
#(
    parameter int NSRC = 6,
    parameter int NCLK = 3,
    parameter int AW   = 2,
    parameter int DW   = 8,
    parameter int RESUME_IDX = 2,
    parameter logic [NSRC-1:0] WAKE_MASK = 6'b000111
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic            clk_stopped_i,
    input  logic [1:0]      mode_i,
    input  logic            refresh_i,
    input  logic            reg_we_i,
    input  logic [AW-1:0]   reg_addr_i,
    input  logic [DW-1:0]   reg_wdata_i,
    output logic [DW-1:0]   reg_rdata_o,
    output logic            smi_o,
    output logic            hs_req_o,
    output logic [NCLK-1:0] run_en_o,
    output logic [1:0]      freq_sel_o
);

    localparam logic [NSRC-1:0] RES_MASK = NSRC'(1) << RESUME_IDX;

    logic [NSRC-1:0] en_w, stat_w, live_w;
    logic            wake_w, en_wr_w, clr_wr_w, ctl_wr_w;
    logic            temp_on_w, rel_pend_w, in_hi, in_pll, res_live;
    pmu_mode_e       mode;
    fsel_e           fsel;

    smi_src_bank #(.NSRC(NSRC), .WAKE_MASK(WAKE_MASK)) u_bank (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .en_wr_i(en_wr_w), .clr_wr_i(clr_wr_w),
        .wdata_i(reg_wdata_i[NSRC-1:0]),
        .en_o(en_w), .stat_o(stat_w), .wake_o(wake_w)
    );

    smi_tempon_seq u_seq (
        .clk(clk), .rst_n(rst_n), .wake_i(wake_w),
        .clk_stopped_i(clk_stopped_i), .ctl_wr_i(ctl_wr_w),
        .refresh_i(refresh_i), .temp_on_o(temp_on_w), .rel_pend_o(rel_pend_w)
    );

    smi_reg_port #(.NSRC(NSRC), .AW(AW), .DW(DW)) u_regs (
        .we_i(reg_we_i), .addr_i(reg_addr_i), .en_i(en_w), .stat_i(stat_w),
        .temp_on_i(temp_on_w), .rel_pend_i(rel_pend_w),
        .en_wr_o(en_wr_w), .clr_wr_o(clr_wr_w), .ctl_wr_o(ctl_wr_w),
        .rdata_o(reg_rdata_o)
    );

    always_comb begin
        mode     = pmu_mode_e'(mode_i);
        in_hi    = (mode == MODE_HI_PLL);
        in_pll   = in_hi || (mode == MODE_LO_PLL);
        live_w   = stat_w & en_w;
        res_live = |(live_w & RES_MASK);
        // resume waits for the high-speed switch before interrupting
        smi_o    = |(live_w & ~RES_MASK) || (res_live && in_hi);
        hs_req_o = res_live && !in_hi;
        unique case (mode)
            MODE_HI_PLL: fsel = FSEL_HI;
            MODE_LO_PLL: fsel = FSEL_LO;
            MODE_DOZE:   fsel = FSEL_REF;
            default:     fsel = FSEL_OFF;
        endcase
        if (temp_on_w && !in_pll) begin
            fsel = FSEL_REF;
        end
        freq_sel_o = fsel;
        run_en_o   = {NCLK{temp_on_w}};
    end

endmodule

// File: rtl/smi_wake_chk.sv
module smi_wake_chk #(
    parameter int NSRC = 6,
    parameter int NCLK = 3,
    parameter int RESUME_IDX = 2,
    parameter logic [NSRC-1:0] WAKE_MASK = 6'b000111
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] evt_i,
    input logic [NSRC-1:0] en,
    input logic [NSRC-1:0] stat,
    input logic            temp_on,
    input logic            rel_pend,
    input logic            refresh_i,
    input logic            clk_stopped_i,
    input logic [1:0]      mode_i,
    input logic            smi_o,
    input logic            hs_req_o,
    input logic [NCLK-1:0] run_en_o,
    input logic [1:0]      freq_sel_o
);

    localparam logic [NSRC-1:0] RES_MASK = NSRC'(1) << RESUME_IDX;

    p_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_i & en) != '0) |=> ((stat & $past(evt_i & en)) == $past(evt_i & en)));

    p_smi_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & en & ~RES_MASK) != '0) |-> smi_o);

    p_wake_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (((evt_i & en & WAKE_MASK) != '0) && clk_stopped_i) |=> (run_en_o == '1));

    p_ref_freq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_on && mode_i[1]) |-> (freq_sel_o == 2'd2));

    p_end_after_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(temp_on) |-> $past(rel_pend && refresh_i));

    p_hs_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hs_req_o |-> ((mode_i != 2'd0) && stat[RESUME_IDX]));

    p_res_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (((stat & en & ~RES_MASK) == '0) && (mode_i != 2'd0)) |-> !smi_o);

endmodule

bind smi_wake_ctrl smi_wake_chk #(
    .NSRC(NSRC), .NCLK(NCLK), .RESUME_IDX(RESUME_IDX), .WAKE_MASK(WAKE_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .en(en_w), .stat(stat_w),
    .temp_on(temp_on_w), .rel_pend(rel_pend_w), .refresh_i(refresh_i),
    .clk_stopped_i(clk_stopped_i), .mode_i(mode_i), .smi_o(smi_o),
    .hs_req_o(hs_req_o), .run_en_o(run_en_o), .freq_sel_o(freq_sel_o)
);

// File: tb/tb_smi_wake_ctrl.sv
module tb_smi_wake_ctrl;

    localparam int NSRC = 6;
    localparam int NCLK = 3;
    localparam int AW   = 2;
    localparam int DW   = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] evt_i = '0;
    logic            clk_stopped_i = 1'b0;
    logic [1:0]      mode_i = 2'd0;
    logic            refresh_i = 1'b0;
    logic            reg_we_i = 1'b0;
    logic [AW-1:0]   reg_addr_i = '0;
    logic [DW-1:0]   reg_wdata_i = '0;
    logic [DW-1:0]   reg_rdata_o;
    logic            smi_o, hs_req_o;
    logic [NCLK-1:0] run_en_o;
    logic [1:0]      freq_sel_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    smi_wake_ctrl dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clk_stopped_i(clk_stopped_i),
        .mode_i(mode_i), .refresh_i(refresh_i), .reg_we_i(reg_we_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .smi_o(smi_o), .hs_req_o(hs_req_o),
        .run_en_o(run_en_o), .freq_sel_o(freq_sel_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_we_i = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
        reg_addr_i = a;
        #1 d = reg_rdata_o;
    endtask

    task automatic pulse(logic [NSRC-1:0] e);
        @(negedge clk);
        evt_i = e;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic tick();
        @(negedge clk);
        refresh_i = 1'b1;
        @(negedge clk);
        refresh_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        mode_i = 2'd3;
        #1;
        check("R10 smi", smi_o, 0);
        check("R10 hs_req", hs_req_o, 0);
        check("R10 run_en", run_en_o, 0);
        check("R5 freq stop", freq_sel_o, 3);
        rd(0, v); check("R10 enable", v, 0);
        rd(1, v); check("R10 status", v, 0);
        rd(2, v); check("R10 ctrl", v, 0);
        mode_i = 2'd0;
    endtask

    task automatic t_disabled();
        logic [DW-1:0] v;
        pulse(6'h20);
        rd(1, v); check("R1 disabled no status", v, 0);
        check("R1 disabled no smi", smi_o, 0);
    endtask

    task automatic t_latch_clear();
        logic [DW-1:0] v;
        wr(0, 8'h3F);
        rd(0, v); check("R9 enable readback", v, 8'h3F);
        pulse(6'h20);
        rd(1, v); check("R1 timer latched", v, 8'h20);
        check("R2 smi high", smi_o, 1);
        check("R4 no run on awake", run_en_o, 0);
        pulse(6'h10);
        wr(1, 8'h20);
        rd(1, v); check("R3 only written bit cleared", v, 8'h10);
        check("R2 smi still high", smi_o, 1);
        wr(1, 8'h10);
        rd(1, v); check("R3 all cleared", v, 0);
        check("R2 smi low", smi_o, 0);
    endtask

    task automatic t_set_wins();
        logic [DW-1:0] v;
        @(negedge clk);
        evt_i = 6'h10; reg_we_i = 1'b1; reg_addr_i = 1; reg_wdata_i = 8'h10;
        @(negedge clk);
        evt_i = '0; reg_we_i = 1'b0;
        rd(1, v); check("R3 set beats clear", v, 8'h10);
        wr(1, 8'h10);
    endtask

    task automatic t_nonwake_stopped();
        logic [DW-1:0] v;
        mode_i = 2'd3; clk_stopped_i = 1'b1;
        pulse(6'h08);
        check("R4 non-wake no run", run_en_o, 0);
        check("R2 non-wake smi", smi_o, 1);
        rd(2, v); check("R9 ctrl idle", v, 0);
        wr(1, 8'h08);
    endtask

    task automatic t_wake_tempon();
        logic [DW-1:0] v;
        mode_i = 2'd3; clk_stopped_i = 1'b1;
        pulse(6'h02);
        check("R4 wake run", run_en_o, 3'b111);
        check("R5 ref freq", freq_sel_o, 2);
        check("R8 battery no hs", hs_req_o, 0);
        rd(2, v); check("R9 ctrl temp_on", v, 8'h01);
        wr(1, 8'h02);
        tick();
        check("R6 tick without write", run_en_o, 3'b111);
        @(negedge clk);
        refresh_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = 2; reg_wdata_i = 8'h00;
        @(negedge clk);
        refresh_i = 1'b0; reg_we_i = 1'b0;
        check("R6 tick with write", run_en_o, 3'b111);
        rd(2, v); check("R9 ctrl pending", v, 8'h03);
        @(negedge clk);
        check("R6 idle after write", run_en_o, 3'b111);
        tick();
        check("R6 ended by tick", run_en_o, 0);
        rd(2, v); check("R6 ctrl cleared", v, 0);
        check("R5 freq back to stop", freq_sel_o, 3);
    endtask

    task automatic t_pll_freq();
        mode_i = 2'd1; clk_stopped_i = 1'b1;
        pulse(6'h01);
        check("R4 mode-change wake", run_en_o, 3'b111);
        check("R5 pll follows mode", freq_sel_o, 1);
        check("R8 mode-change no hs", hs_req_o, 0);
        wr(1, 8'h01);
        wr(2, 8'h00);
        tick();
        check("R6 pll ended", run_en_o, 0);
    endtask

    task automatic t_resume();
        mode_i = 2'd3; clk_stopped_i = 1'b1;
        pulse(6'h04);
        check("R7 hs_req raised", hs_req_o, 1);
        check("R7 smi held", smi_o, 0);
        check("R4 resume wake", run_en_o, 3'b111);
        @(negedge clk);
        mode_i = 2'd0;
        #1;
        check("R7 hs_req dropped", hs_req_o, 0);
        check("R7 smi released", smi_o, 1);
        check("R5 hi freq", freq_sel_o, 0);
        wr(1, 8'h04);
        check("R2 smi cleared", smi_o, 0);
        wr(2, 8'h00);
        tick();
        clk_stopped_i = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_disabled();
        t_latch_clear();
        t_set_wins();
        t_nonwake_stopped();
        t_wake_tempon();
        t_pll_freq();
        t_resume();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule